// File: doc/BRIEF.md
# Bridge Parity Error Reporting Unit

This unit collects the data parity error outcomes of a two-port bus bridge and turns them into the primary-side status flags and a system-error strobe. The transaction engine drives it with one event per cycle. Each event carries the transaction kind, its direction, the bus on which the bridge itself saw bad parity, whether the target on the primary bus reported a parity error, and whether the error had already been forwarded from the initiating bus. Configuration enables come from the primary command register and the secondary bridge-control register.

There are three sticky flags. Data-parity-detected records a target-reported error on an upstream write. Detected-parity-error records bad parity seen by the bridge on the primary bus for the kinds of transaction that count. Signaled-system-error records that the system-error output was pulsed. Software clears a flag by writing a 1 to its position. A write of 0 leaves the flag alone. When an event and a clear hit the same flag in the same cycle, the event wins.

Top module: `brg_perr_report`

## Requirements
- R1: An active-low synchronous reset clears all three status flags and drives `serr_n` high.
- R2: An upstream posted or delayed write with `tgt_perr` set raises status bit 0 (data parity detected) one cycle later, but only when `cfg_pri_perr_rsp` is 1.
- R3: The same upstream-write event drives `serr_n` low in the next cycle and raises status bit 2 (signaled system error) only when `cfg_serr_en`, `cfg_sec_perr_rsp` and `cfg_pri_perr_rsp` are all 1.
- R4: When `err_fwd` is 1, the event neither pulses `serr_n` nor raises status bit 2.
- R5: Status bit 1 (detected parity error) is raised when `evt_on_sec` is 0 (primary bus) and the event is one of three kinds: an upstream read (kind 00, `evt_up`=1), a downstream posted write (kind 01, `evt_up`=0) or a downstream delayed write (kind 10, `evt_up`=0). Neither parity response enable affects this.
- R6: Any other combination of kind, direction and bus leaves status bit 1 unchanged.
- R7: `serr_n` is low for exactly one cycle per qualifying event and returns high in the following cycle when no new event qualifies.
- R8: Flags are sticky. With `sw_clr_we` set, a 1 in `sw_clr_mask` clears the flag at that position and a 0 leaves it unchanged.
- R9: If an event sets a flag in the same cycle that software clears it, the flag ends up set.
- R10: A read with `tgt_perr`, a downstream write with `tgt_perr`, or any event of reserved kind 11 never raises bit 0 or bit 2 and never pulses `serr_n`. Kind 11 also leaves bit 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_kind | input | 2 | 00 read, 01 posted write, 10 delayed write, 11 reserved |
| evt_up | input | 1 | 1 upstream, 0 downstream |
| evt_on_sec | input | 1 | Bus where the bridge saw the error: 1 secondary, 0 primary |
| tgt_perr | input | 1 | Target on the primary bus reported a data parity error |
| err_fwd | input | 1 | The error was forwarded from the initiating bus |
| cfg_pri_perr_rsp | input | 1 | Primary command register parity response enable |
| cfg_serr_en | input | 1 | Primary command register system-error enable |
| cfg_sec_perr_rsp | input | 1 | Secondary bridge-control parity response enable |
| sw_clr_we | input | 1 | Software write strobe for the status flags |
| sw_clr_mask | input | 3 | Write-1-to-clear data, bit 0 DPD, bit 1 DPE, bit 2 SSE |
| status | output | 3 | Sticky flags: bit 0 DPD, bit 1 DPE, bit 2 SSE |
| serr_n | output | 1 | System-error strobe, active low |

## Verification
On every cycle the assertions check several things. Every low cycle on `serr_n` must trace back to a qualifying event that was not forwarded, and it must have raised the signaled-system-error flag. The strobe must release when no new event arrives. A set flag must survive any cycle without a matching clear, and a set request must beat a same-cycle clear. A newly raised detected-parity-error flag must come from a primary-bus event. Only the bench scenarios can show the full decision tables: which kind, direction and bus combinations raise a flag, and how each of the three enables gates the upstream-write outcome. The bench also covers selective clearing, the write of 0 that has no effect, and reset in the middle of a run.

// File: rtl/brg_perr_pkg.sv
package brg_perr_pkg;

   typedef enum logic [1:0] {
      XK_READ    = 2'b00,
      XK_POSTED  = 2'b01,
      XK_DELAYED = 2'b10,
      XK_RSVD    = 2'b11
   } xact_kind_e;

   localparam int unsigned ST_COUNT = 3;
   localparam int unsigned ST_DPD   = 0;
   localparam int unsigned ST_DPE   = 1;
   localparam int unsigned ST_SSE   = 2;

endpackage

// File: rtl/brg_perr_decode.sv
module brg_perr_decode
   import brg_perr_pkg::*;
#(
   parameter int unsigned STAT_W = ST_COUNT
) (
   input  logic              evt_valid,
   input  xact_kind_e        evt_kind,
   input  logic              evt_up,
   input  logic              evt_on_sec,
   input  logic              tgt_perr,
   input  logic              err_fwd,
   input  logic              cfg_pri_perr_rsp,
   input  logic              cfg_serr_en,
   input  logic              cfg_sec_perr_rsp,
   output logic [STAT_W-1:0] set_req,
   output logic              serr_fire
);

   logic known_kind;
   logic is_write;
   logic is_read;
   logic up_tgt_err;
   logic dpe_hit;

   always_comb begin
      known_kind = evt_valid && (evt_kind != XK_RSVD);
      is_read    = (evt_kind == XK_READ);
      is_write   = (evt_kind == XK_POSTED) || (evt_kind == XK_DELAYED);
      // target on primary flagged bad data on an upstream write
      up_tgt_err = known_kind && is_write && evt_up && tgt_perr;
      // bridge itself saw bad parity on primary for counted kinds
      dpe_hit    = known_kind && !evt_on_sec &&
                   ((is_read && evt_up) || (is_write && !evt_up));
      serr_fire  = up_tgt_err && cfg_pri_perr_rsp && cfg_serr_en &&
                   cfg_sec_perr_rsp && !err_fwd;
      set_req            = '0;
      set_req[ST_DPD]    = up_tgt_err && cfg_pri_perr_rsp;
      set_req[ST_DPE]    = dpe_hit;
      set_req[ST_SSE]    = serr_fire;
   end

endmodule

// File: rtl/brg_perr_sticky.sv
module brg_perr_sticky #(
   parameter int unsigned STAT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] set_req,
   input  logic              clr_we,
   input  logic [STAT_W-1:0] clr_mask,
   output logic [STAT_W-1:0] stat_q
);

   for (genvar gi = 0; gi < STAT_W; gi++) begin : g_flag
      logic clr_hit;
      assign clr_hit = clr_we && clr_mask[gi];

      always_ff @(posedge clk) begin
         if (!rst_n)
            stat_q[gi] <= 1'b0;
         else
            stat_q[gi] <= set_req[gi] || (stat_q[gi] && !clr_hit);
      end

      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         stat_q[gi] && !clr_hit |=> stat_q[gi]);                      // R8
      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         set_req[gi] |=> stat_q[gi]);                                  // R9
   end

endmodule

// File: rtl/brg_perr_serr_drv.sv
module brg_perr_serr_drv (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic serr_n
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         serr_n <= 1'b1;
      else
         serr_n <= !fire;
   end

   AST_SERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |-> $past(fire));                                        // R3
   AST_SERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> serr_n);                                               // R7

endmodule

// File: rtl/brg_perr_report.sv
module brg_perr_report
   import brg_perr_pkg::*;
#(
   parameter int unsigned KIND_W = 2,
   parameter int unsigned STAT_W = ST_COUNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [KIND_W-1:0] evt_kind,
   input  logic              evt_up,
   input  logic              evt_on_sec,
   input  logic              tgt_perr,
   input  logic              err_fwd,
   input  logic              cfg_pri_perr_rsp,
   input  logic              cfg_serr_en,
   input  logic              cfg_sec_perr_rsp,
   input  logic              sw_clr_we,
   input  logic [STAT_W-1:0] sw_clr_mask,
   output logic [STAT_W-1:0] status,
   output logic              serr_n
);

   localparam int unsigned KIND_EXPECT = $bits(xact_kind_e);

   if (KIND_W != KIND_EXPECT) begin : g_bad_kind_w
      $error("KIND_W must match the transaction kind encoding width");
   end
   if (STAT_W != ST_COUNT) begin : g_bad_stat_w
      $error("STAT_W must equal the number of status flags");
   end

   logic [STAT_W-1:0] set_req;
   logic              serr_fire;

   brg_perr_decode #(.STAT_W(STAT_W)) i_decode (
      .evt_valid        (evt_valid),
      .evt_kind         (xact_kind_e'(evt_kind)),
      .evt_up           (evt_up),
      .evt_on_sec       (evt_on_sec),
      .tgt_perr         (tgt_perr),
      .err_fwd          (err_fwd),
      .cfg_pri_perr_rsp (cfg_pri_perr_rsp),
      .cfg_serr_en      (cfg_serr_en),
      .cfg_sec_perr_rsp (cfg_sec_perr_rsp),
      .set_req          (set_req),
      .serr_fire        (serr_fire)
   );

   brg_perr_sticky #(.STAT_W(STAT_W)) i_sticky (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (set_req),
      .clr_we   (sw_clr_we),
      .clr_mask (sw_clr_mask),
      .stat_q   (status)
   );

   brg_perr_serr_drv i_serr (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (serr_fire),
      .serr_n (serr_n)
   );

   AST_SERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |-> status[ST_SSE]);                                     // R3
   AST_NO_SERR_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |-> $past(evt_valid && !err_fwd));                       // R4
   AST_DPE_FROM_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_DPE] && !$past(status[ST_DPE]) |-> $past(evt_valid && !evt_on_sec)); // R5

endmodule

// File: tb/test_brg_perr_report.sv
module test_brg_perr_report;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       evt_valid;
   logic [1:0] evt_kind;
   logic       evt_up, evt_on_sec, tgt_perr, err_fwd;
   logic       cfg_pri_perr_rsp, cfg_serr_en, cfg_sec_perr_rsp;
   logic       sw_clr_we;
   logic [2:0] sw_clr_mask;
   logic [2:0] status;
   logic       serr_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   brg_perr_report i_brg_perr_report (
      .clk              (clk),
      .rst_n            (rst_n),
      .evt_valid        (evt_valid),
      .evt_kind         (evt_kind),
      .evt_up           (evt_up),
      .evt_on_sec       (evt_on_sec),
      .tgt_perr         (tgt_perr),
      .err_fwd          (err_fwd),
      .cfg_pri_perr_rsp (cfg_pri_perr_rsp),
      .cfg_serr_en      (cfg_serr_en),
      .cfg_sec_perr_rsp (cfg_sec_perr_rsp),
      .sw_clr_we        (sw_clr_we),
      .sw_clr_mask      (sw_clr_mask),
      .status           (status),
      .serr_n           (serr_n)
   );

   // {kind[1:0], up, on_sec, tgt_perr, fwd, pri_rsp, serr_en, sec_rsp, exp_status[2:0], exp_serr_low}
   localparam logic [12:0] VEC [17] = '{
      13'b00_1000_000_010_0,  // R5 upstream read, primary, enables off
      13'b01_0000_000_010_0,  // R5 downstream posted write, primary
      13'b10_0000_111_010_0,  // R5 downstream delayed write, primary
      13'b00_0000_111_000_0,  // R6 downstream read
      13'b00_1100_111_000_0,  // R6 upstream read, secondary
      13'b01_1000_111_000_0,  // R6 upstream posted write, no target error
      13'b10_1100_111_000_0,  // R6 upstream delayed write, secondary
      13'b01_0100_111_000_0,  // R6 downstream posted write, secondary
      13'b01_1010_111_101_1,  // R2 R3 upstream posted write, target error
      13'b01_1011_111_001_0,  // R4 forwarded
      13'b01_1010_011_000_0,  // R2 primary response off
      13'b10_1010_101_001_0,  // R3 serr enable off
      13'b10_1010_110_001_0,  // R3 secondary response off
      13'b10_1010_111_101_1,  // R3 upstream delayed write, all enables
      13'b00_1010_111_010_0,  // R10 read with target error
      13'b11_1010_111_000_0,  // R10 reserved kind
      13'b01_0010_111_010_0   // R10 downstream write with target error
   };

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      evt_valid = 0; evt_kind = 2'b00; evt_up = 0; evt_on_sec = 0;
      tgt_perr = 0; err_fwd = 0;
      cfg_pri_perr_rsp = 0; cfg_serr_en = 0; cfg_sec_perr_rsp = 0;
      sw_clr_we = 0; sw_clr_mask = 3'b000;
   endtask

   task automatic drive_vec(input logic [8:0] v);
      evt_valid = 1;
      {evt_kind, evt_up, evt_on_sec, tgt_perr, err_fwd,
       cfg_pri_perr_rsp, cfg_serr_en, cfg_sec_perr_rsp} = v;
   endtask

   task automatic clear_all();
      @(negedge clk);
      idle_inputs();
      sw_clr_we = 1; sw_clr_mask = 3'b111;
      @(negedge clk);
      sw_clr_we = 0; sw_clr_mask = 3'b000;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset state", {status, serr_n}, 4'b0001);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after release", {status, serr_n}, 4'b0001);

      // table walk: clear, present one event, sample one edge later
      for (int i = 0; i < 17; i++) begin
         clear_all();
         drive_vec(VEC[i][12:4]);
         @(negedge clk);
         idle_inputs();
         chk($sformatf("R2 R3 R4 R5 R6 R10 vector %0d", i),
             {status, serr_n}, {VEC[i][3:1], ~VEC[i][0]});
         @(negedge clk);
         chk($sformatf("R7 strobe released vector %0d", i),
             {status, serr_n}, {VEC[i][3:1], 1'b1});
      end

      // R7: two adjacent events give two low cycles, then release
      clear_all();
      drive_vec(9'b01_1010_111);
      @(negedge clk);
      chk("R7 first pulse", {3'b000, serr_n}, 4'b0000);
      @(negedge clk);
      idle_inputs();
      chk("R7 second pulse", {3'b000, serr_n}, 4'b0000);
      @(negedge clk);
      chk("R7 release after burst", {3'b000, serr_n}, 4'b0001);

      // R8: stickiness and write-1-to-clear
      clear_all();
      drive_vec(9'b00_1000_000);   // sets bit 1
      @(negedge clk);
      drive_vec(9'b01_1010_111);   // sets bits 0 and 2
      @(negedge clk);
      idle_inputs();
      repeat (3) @(negedge clk);
      chk("R8 flags hold", {status, serr_n}, 4'b1111);
      sw_clr_we = 1; sw_clr_mask = 3'b000;
      @(negedge clk);
      sw_clr_we = 0;
      chk("R8 write of zero", {status, serr_n}, 4'b1111);
      sw_clr_we = 0; sw_clr_mask = 3'b111;
      @(negedge clk);
      chk("R8 mask without strobe", {status, serr_n}, 4'b1111);
      sw_clr_we = 1; sw_clr_mask = 3'b010;
      @(negedge clk);
      idle_inputs();
      chk("R8 selective clear", {status, serr_n}, 4'b1011);

      // R9: set and clear of bit 1 in the same cycle
      drive_vec(9'b01_0000_000);
      sw_clr_we = 1; sw_clr_mask = 3'b111;
      @(negedge clk);
      idle_inputs();
      chk("R9 set beats clear", {status, serr_n}, 4'b0101);

      // R1: reset in the middle of a run
      drive_vec(9'b10_1010_111);
      @(negedge clk);
      idle_inputs();
      rst_n = 0;
      @(negedge clk);
      chk("R1 mid-run reset", {status, serr_n}, 4'b0001);
      rst_n = 1;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule